// File: doc/BRIEF.md
# Cyclic Converter Sequencer with Bias Scheduling

This block is the timing controller of a cyclic (algorithmic) analog-to-digital converter. The converter reuses one amplifier stage for every bit, so the controller walks it through a fixed chain of conversion states. Each state lasts exactly one clock. Inside each clock, two residue phases are marked by a half-clock phase output. The resolution select decides where the chain starts. A 12-bit conversion starts at ST1 and takes 6 clocks. A 10-bit conversion starts at ST2 and takes 5 clocks. An 8-bit conversion starts at ST3 and takes 4 clocks. Every conversion then passes through ST4, ST5 and FINAL.

In each state the sequencer drives the following controls:
- the sample-and-hold connection and the enables of the two residue networks;
- the amplifier output-short pulse;
- the final 2-bit flash enable;
- the output-register update strobe;
- start-of-conversion and end-of-conversion pulses for the correction logic;
- a registered bias-current code.

The bias code falls as the bits being resolved need less precision.

The states are IDLE, ST1, ST2, ST3, ST4, ST5 and FINAL. The transitions are:
- IDLE to the entry state, when enabled;
- each ST state to the next one, with ST5 going to FINAL;
- FINAL back to the entry state chosen by the resolution select at that moment;
- any state to IDLE whenever the enable is low.

Top module: `cyc_adc_sequencer`

## Requirements
- R1: While `rst_n` is low, every output is 0 and the sequencer is in IDLE.
- R2: The entry state is chosen by `res_sel`: 2'b00 selects 8 bits and ST3, 2'b01 selects 10 bits and ST2, 2'b10 or 2'b11 selects 12 bits and ST1. Back-to-back conversions therefore repeat every 4, 5 or 6 clocks.
- R3: After entry, the states advance one per clock through ST4 and ST5 to FINAL. FINAL is followed by a new entry state while `run_en` stays high.
- R4: In the first state of a conversion, `sh_connect`=1, `net_a_en`=1 and `net_b_en`=0. In every later state of that conversion, `sh_connect`=0 and both net enables are 1.
- R5: `amp_reset` is high only during the high half of the clock in the first state of a conversion.
- R6: `fin_flash_en` is 1 only in FINAL.
- R7: `bias_code` is given in tenths of full current: ST1=10, ST2=5, ST3=4, ST4=4, ST5=3, FINAL=3, IDLE=0.
- R8: `bias_code` changes only at a rising clock edge that changes the state. It does not move at the falling edge.
- R9: A change of `res_sel` in the middle of a conversion does not alter that conversion. It takes effect at the next entry after FINAL.
- R10: When `run_en` is low at a rising edge, the next state is IDLE. In IDLE all enables, `phase` and `amp_reset` are 0, and `bias_code` is 0.
- R11: In any active state, `phase` is 0 in the high half of the clock (first residue phase) and 1 in the low half (second phase). In IDLE it is 0.
- R12: `conv_start` is 1 in the first state of every conversion. `out_update` is 1 only in a first state entered directly from FINAL.
- R13: `conv_done` is 1 for the one clock after FINAL, whether that clock is a new entry state or IDLE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Converter clock; both halves are used as residue phases |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | Run enable; low parks the sequencer in IDLE |
| res_sel | input | 2 | Resolution select: 00 = 8 bits, 01 = 10 bits, 1x = 12 bits |
| sh_connect | output | 1 | Sample-and-hold network connected to the amplifier |
| net_a_en | output | 1 | Residue network A enable |
| net_b_en | output | 1 | Residue network B enable |
| amp_reset | output | 1 | Amplifier output short, first phase of the first state |
| fin_flash_en | output | 1 | Final 2-bit flash enable |
| out_update | output | 1 | Converter output register update strobe |
| conv_start | output | 1 | Start-of-conversion pulse |
| conv_done | output | 1 | End-of-conversion pulse, one clock after FINAL |
| phase | output | 1 | Residue phase marker (0 = first half, 1 = second half) |
| bias_code | output | 4 | Bias current in tenths of full scale |

## Verification
Several functions can fall in the same clock:
- When conversions run back to back, `conv_done` of one conversion lands in the same clock as `conv_start`, `out_update` and `sh_connect` of the next.
- When the enable is dropped during FINAL, `conv_done` must still appear while every enable and the bias code have already gone to zero in IDLE.

The bench provokes both cases:
- It runs uninterrupted conversions at every resolution.
- It removes `run_en` in the low half of the clock in which `fin_flash_en` is seen.

A cycle-level reference model built from the requirements judges every output in both clock halves of every tick.

// File: rtl/cyc_seq_pkg.sv
package cyc_seq_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_ST1   = 3'd1,
        S_ST2   = 3'd2,
        S_ST3   = 3'd3,
        S_ST4   = 3'd4,
        S_ST5   = 3'd5,
        S_FINAL = 3'd6
    } seq_state_e;

    // Resolution select encodings
    localparam logic [1:0] RES_8B  = 2'b00;
    localparam logic [1:0] RES_10B = 2'b01;

    // Entry state of a conversion for a given resolution select
    function automatic seq_state_e entry_state(input logic [1:0] sel);
        seq_state_e s;
        unique case (sel)
            RES_8B:  s = S_ST3;
            RES_10B: s = S_ST2;
            default: s = S_ST1;
        endcase
        return s;
    endfunction

    // Scheduled bias level in tenths of full current
    function automatic int unsigned bias_tenths(input seq_state_e s);
        int unsigned b;
        unique case (s)
            S_ST1:            b = 10;
            S_ST2:            b = 5;
            S_ST3, S_ST4:     b = 4;
            S_ST5, S_FINAL:   b = 3;
            default:          b = 0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/cyc_seq_fsm.sv
module cyc_seq_fsm
    import cyc_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_en,
    input  logic [1:0] res_sel,
    output seq_state_e state_q,
    output seq_state_e state_d,
    output logic       enter_d
);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = S_IDLE;
        enter_d = 1'b0;
        if (run_en) begin
            unique case (state_q)
                S_IDLE, S_FINAL: begin
                    state_d = entry_state(res_sel);
                    enter_d = 1'b1;
                end
                S_ST1:   state_d = S_ST2;
                S_ST2:   state_d = S_ST3;
                S_ST3:   state_d = S_ST4;
                S_ST4:   state_d = S_ST5;
                S_ST5:   state_d = S_FINAL;
                default: state_d = S_IDLE;
            endcase
        end
    end

    AST_FINAL_AFTER_ST5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_FINAL) |-> ($past(state_q) == S_ST5)); // R3

    AST_PARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> (state_q == S_IDLE)); // R10

endmodule

// File: rtl/cyc_seq_ctrl.sv
module cyc_seq_ctrl
    import cyc_seq_pkg::*;
#(
    parameter int BIAS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  seq_state_e        state_q,
    input  seq_state_e        state_d,
    input  logic              enter_d,
    output logic              first_q,
    output logic              active_q,
    output logic              net_b_q,
    output logic              flash_q,
    output logic              update_q,
    output logic              done_q,
    output logic [BIAS_W-1:0] bias_q
);

    localparam int unsigned FULL_CODE = 10;
    localparam int unsigned BIAS_MAX  = (1 << BIAS_W) - 1;

    initial begin
        if (FULL_CODE > BIAS_MAX) $error("bias code width too small");
    end

    // Output registers, loaded from the next-state decode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            first_q  <= 1'b0;
            active_q <= 1'b0;
            net_b_q  <= 1'b0;
            flash_q  <= 1'b0;
            update_q <= 1'b0;
            done_q   <= 1'b0;
            bias_q   <= '0;
        end else begin
            first_q  <= enter_d;
            active_q <= (state_d != S_IDLE);
            net_b_q  <= (state_d != S_IDLE) && !enter_d;
            flash_q  <= (state_d == S_FINAL);
            update_q <= enter_d && (state_q == S_FINAL);
            done_q   <= (state_q == S_FINAL);
            bias_q   <= BIAS_W'(bias_tenths(state_d));
        end
    end

    AST_ONE_NET_AT_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        first_q |-> (!net_b_q && active_q)); // R4

    AST_BIAS_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        net_b_q |-> (bias_q <= $past(bias_q))); // R7

    AST_FLASH_NOT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        flash_q |-> !first_q); // R6

endmodule

// File: rtl/cyc_adc_sequencer.sv
module cyc_adc_sequencer
    import cyc_seq_pkg::*;
#(
    parameter int BIAS_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_en,
    input  logic [1:0]        res_sel,
    output logic              sh_connect,
    output logic              net_a_en,
    output logic              net_b_en,
    output logic              amp_reset,
    output logic              fin_flash_en,
    output logic              out_update,
    output logic              conv_start,
    output logic              conv_done,
    output logic              phase,
    output logic [BIAS_W-1:0] bias_code
);

    seq_state_e state_q;
    seq_state_e state_d;
    logic       enter_d;
    logic       first_q;
    logic       active_q;

    cyc_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_en  (run_en),
        .res_sel (res_sel),
        .state_q (state_q),
        .state_d (state_d),
        .enter_d (enter_d)
    );

    cyc_seq_ctrl #(.BIAS_W(BIAS_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .state_q  (state_q),
        .state_d  (state_d),
        .enter_d  (enter_d),
        .first_q  (first_q),
        .active_q (active_q),
        .net_b_q  (net_b_en),
        .flash_q  (fin_flash_en),
        .update_q (out_update),
        .done_q   (conv_done),
        .bias_q   (bias_code)
    );

    assign sh_connect = first_q;
    assign conv_start = first_q;
    assign net_a_en   = active_q;

    // Half-clock phase marking: high half is phase 0, low half is phase 1
    assign phase     = active_q & ~clk;
    assign amp_reset = first_q & clk;

    AST_BIAS_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(bias_code) |-> !$stable(state_q)); // R8

    AST_DONE_AFTER_FLASH: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |-> $past(fin_flash_en)); // R13

    AST_IDLE_NO_BIAS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE) |-> (bias_code == '0 && !net_a_en && !fin_flash_en)); // R10

endmodule

// File: tb/test_cyc_adc_sequencer.sv
module test_cyc_adc_sequencer;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic [1:0] res_sel = 2'b10;
    logic       sh_connect, net_a_en, net_b_en, amp_reset, fin_flash_en;
    logic       out_update, conv_start, conv_done, phase;
    logic [3:0] bias_code;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // reference model state: 0 idle, 1..5 ST1..ST5, 6 final
    int m_st = 0;
    bit m_first, m_upd, m_done;
    int tick_no = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cyc_adc_sequencer i_cyc_adc_sequencer (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_en       (run_en),
        .res_sel      (res_sel),
        .sh_connect   (sh_connect),
        .net_a_en     (net_a_en),
        .net_b_en     (net_b_en),
        .amp_reset    (amp_reset),
        .fin_flash_en (fin_flash_en),
        .out_update   (out_update),
        .conv_start   (conv_start),
        .conv_done    (conv_done),
        .phase        (phase),
        .bias_code    (bias_code)
    );

    function automatic int entry_of(input logic [1:0] r);
        if (r == 2'b00) return 3;
        if (r == 2'b01) return 2;
        return 1;
    endfunction

    function automatic int bias_of(input int s);
        case (s)
            1: return 10;
            2: return 5;
            3, 4: return 4;
            5, 6: return 3;
            default: return 0;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s at tick %0d: got %0d expected %0d", tag, tick_no, act, exp);
        end
    endtask

    // One clock: model update at the rising edge, checks in both halves
    task automatic tick();
        int nxt;
        @(posedge clk);
        tick_no++;
        if (!rst_n) begin
            nxt = 0; m_first = 0; m_upd = 0; m_done = 0;
        end else begin
            m_first = run_en && (m_st == 0 || m_st == 6);
            m_upd   = m_first && (m_st == 6);
            m_done  = (m_st == 6);
            if (!run_en) nxt = 0;
            else if (m_st == 0 || m_st == 6) nxt = entry_of(res_sel);
            else nxt = m_st + 1;
        end
        m_st = nxt;
        #2;
        check("R5 amp_reset high half", int'(amp_reset), int'(m_first));
        check("R11 phase high half", int'(phase), 0);
        check("R7 bias_code", int'(bias_code), bias_of(m_st));
        @(negedge clk);
        #1;
        check("R4 sh_connect", int'(sh_connect), int'(m_first));
        check("R4 net_a_en", int'(net_a_en), int'(m_st != 0));
        check("R4 net_b_en", int'(net_b_en), int'(m_st != 0 && !m_first));
        check("R6 fin_flash_en", int'(fin_flash_en), int'(m_st == 6));
        check("R12 conv_start", int'(conv_start), int'(m_first));
        check("R12 out_update", int'(out_update), int'(m_upd));
        check("R13 conv_done", int'(conv_done), int'(m_done));
        check("R11 phase low half", int'(phase), int'(m_st != 0));
        check("R5 amp_reset low half", int'(amp_reset), 0);
        check("R8 bias_code low half", int'(bias_code), bias_of(m_st));
    endtask

    task automatic t_reset();
        rst_n = 1'b0; run_en = 1'b1;
        tick(); tick();
        // R1: all outputs zero in reset
        check("R1 outputs in reset",
              int'({sh_connect, net_a_en, net_b_en, fin_flash_en, out_update,
                    conv_start, conv_done, phase, amp_reset, bias_code}), 0);
        run_en = 1'b0;
        rst_n = 1'b1;
        tick();
    endtask

    // Run conversions back to back and measure the start-to-start period
    task automatic t_run_res(input logic [1:0] r, input int exp_len);
        int last = -1;
        int seen = 0;
        res_sel = r; run_en = 1'b1;
        for (int k = 0; k < exp_len * 3 + 1; k++) begin
            tick();
            if (conv_start) begin
                check("R2 entry bias", int'(bias_code), bias_of(entry_of(r)));
                if (last >= 0) begin
                    check("R2 clocks per conversion", tick_no - last, exp_len);
                    seen++;
                end
                last = tick_no;
            end
            if (fin_flash_en && last >= 0)
                check("R3 FINAL position", tick_no - last, exp_len - 1);
        end
        check("R2 periods observed", int'(seen >= 2), 1);
        run_en = 1'b0;
        tick(); tick();
    endtask

    // Change resolution mid conversion: current one keeps its length
    task automatic t_res_change();
        int s0;
        res_sel = 2'b10; run_en = 1'b1;
        tick();
        check("R9 start 12b", int'(conv_start), 1);
        s0 = tick_no;
        tick(); tick();
        res_sel = 2'b00;
        while (!conv_start) tick();
        check("R9 old length kept", tick_no - s0, 6);
        check("R9 new entry is ST3", int'(bias_code), 4);
        s0 = tick_no;
        tick();
        while (!conv_start) tick();
        check("R9 new length", tick_no - s0, 4);
    endtask

    // Drop enable mid conversion
    task automatic t_disable_mid();
        tick();
        run_en = 1'b0;
        tick();
        check("R10 idle bias", int'(bias_code), 0);
        check("R10 idle enables", int'({net_a_en, net_b_en, sh_connect, fin_flash_en}), 0);
        tick();
    endtask

    // Drop enable while FINAL is seen: done still fires into IDLE
    task automatic t_stop_at_final();
        res_sel = 2'b01; run_en = 1'b1;
        tick();
        while (!fin_flash_en) tick();
        run_en = 1'b0;
        tick();
        check("R13 done into idle", int'(conv_done), 1);
        check("R10 idle after final", int'({net_a_en, bias_code}), 0);
        // Restart from IDLE: start without output update
        run_en = 1'b1;
        tick();
        check("R12 start from idle", int'(conv_start), 1);
        check("R12 no update from idle", int'(out_update), 0);
        run_en = 1'b0;
        tick(); tick();
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_run_res(2'b10, 6);
        t_run_res(2'b01, 5);
        t_run_res(2'b00, 4);
        t_run_res(2'b11, 6);
        t_res_change();
        t_disable_mid();
        t_stop_at_final();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule